// File: doc/BRIEF.md
# I2C Slave Front End for a Display Controller

This block sits between a two-wire serial bus and the core of a matrix display driver. It watches already-synchronized copies of the bus clock and data lines on the system clock, recognises START and STOP conditions, and accepts transfers sent to its own 7-bit address. The upper five address bits are fixed at 01111. The two low bits come from board straps, so four of these devices can share one bus.

In a write transfer, the first byte after the address is a control byte. Its top bit selects between two modes: a single data byte followed by another control byte, or an unbroken run of data bytes up to the end of the transfer. The next bit selects where the data goes: to the command decoder as a setup byte, or to display memory. Each received data byte appears downstream as a one-cycle valid strobe with its byte. In a read transfer, the block shifts out status bytes taken from a status input for as long as the master keeps acknowledging. Read data leaves on a dedicated open-drain output enable, separate from the data input.

The downstream interfaces are valid-only streams. The bus cannot be stalled, so there is no ready signal and no back-pressure. A sink must take every strobe in the cycle it is asserted, and strobes are always many system clocks apart.

Top module: `i2c_dispctl_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 01111 followed by addr_sel[1:0]. For any other address it drives nothing and produces no strobes until the next START.
- R2: In a write transfer the block acknowledges the matching address byte, every control byte and every data byte by asserting sda_oe_o (pulling SDA low) for the ninth clock of that byte.
- R3: In a control byte, bit 7 is the continuation flag Co and bit 6 is the routing flag D/C. Bits 5 to 0 have no effect on the block.
- R4: When Co=1, exactly one data byte follows the control byte, and the byte after that is decoded as a new control byte.
- R5: When Co=0, every later byte of the same transfer is data, until a STOP or a repeated START.
- R6: A data byte received with D/C=0 gives a one-cycle cmd_valid_o pulse with the byte on cmd_data_o. A data byte received with D/C=1 gives a one-cycle ram_valid_o pulse with the byte on ram_data_o.
- R7: In a read transfer with D/C=0, each byte sent starts with a one-cycle stat_req_o pulse, in which stat_data_i is captured. The byte is sent MSB first, with sda_oe_o=1 for a 0 bit. Bytes continue while the master acknowledges. After a master NOT-acknowledge the block releases SDA and requests nothing more.
- R8: In a read transfer with D/C=1, every data bit is released (the master reads 0xFF) and stat_req_o stays low.
- R9: A repeated START at any point, including mid-byte, returns the block to the address phase. The first byte after a matching write address is always a control byte.
- R10: D/C resets to 0 and keeps its value across STOP and repeated START until the next control byte. The continuation mode ends at STOP or repeated START.
- R11: sda_oe_o changes only while SCL is low.
- R12: At most one of cmd_valid_o, ram_valid_o and stat_req_o is high in any cycle, and each is high for a single cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data |
| addr_sel | input | 2 | Strap bits forming the two low address bits |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| cmd_valid_o | output | 1 | Command byte strobe |
| cmd_data_o | output | 8 | Command byte |
| ram_valid_o | output | 1 | Display-memory byte strobe |
| ram_data_o | output | 8 | Display-memory byte |
| stat_req_o | output | 1 | Status byte capture strobe |
| stat_data_i | input | 8 | Status byte to return on a read |

## Verification
Three situations are hard to reach from the ports. The first is a repeated START that lands part-way through a byte, after a data stream is already running. The bench reaches it with a task that clocks only a few bits before raising a new START. The second is the D/C value surviving a STOP and a repeated START. To expose it, the bench makes reads whose returned bytes depend on a control byte sent in an earlier or interrupted transfer. The third is the address decoder, which the bench checks by sweeping every 7-bit address under every strap setting.

// File: rtl/dc_i2c_pkg.sv
package dc_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CTRL,
    BK_DATA
  } bytekind_t;
endpackage

// File: rtl/dc_bus_events.sv
module dc_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dc_link_fsm.sv
module dc_link_fsm
  import dc_i2c_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-SEL_W-1:0] ADDR_HI = 5'b01111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic [DATA_W-1:0] stat_data_i,
  output logic              sda_oe,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              dc_q,
  output logic              stat_req
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
  localparam int CO_BIT = DATA_W - 1;
  localparam int DC_BIT = DATA_W - 2;

  phase_t            phase;
  bytekind_t         kind;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, txreg;
  logic              co_q, rd_mode, nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kind      <= BK_ADDR;
      cnt       <= '0;
      shreg     <= '0;
      txreg     <= '1;
      co_q      <= 1'b0;
      dc_q      <= 1'b0;
      rd_mode   <= 1'b0;
      nack_q    <= 1'b1;
      byte_done <= 1'b0;
      stat_req  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      stat_req  <= 1'b0;
      if (start_det) begin
        phase   <= PH_RX;
        kind    <= BK_ADDR;
        cnt     <= '0;
        co_q    <= 1'b0;
        rd_mode <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        co_q    <= 1'b0;
        rd_mode <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise && cnt != LAST) begin
              shreg <= {shreg[DATA_W-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              unique case (kind)
                BK_ADDR: begin
                  if (shreg[DATA_W-1 -: ADDR_W] == {ADDR_HI, addr_sel}) begin
                    phase   <= PH_ACK;
                    rd_mode <= shreg[0];
                    kind    <= BK_CTRL;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                BK_CTRL: begin
                  co_q  <= shreg[CO_BIT];
                  dc_q  <= shreg[DC_BIT];
                  phase <= PH_ACK;
                  kind  <= BK_DATA;
                end
                default: begin
                  byte_done <= 1'b1;
                  phase     <= PH_ACK;
                  kind      <= co_q ? BK_CTRL : BK_DATA;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                phase    <= PH_TX;
                cnt      <= CNT_W'(1);
                txreg    <= dc_q ? '1 : stat_data_i;
                stat_req <= ~dc_q;
              end else begin
                phase <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                phase <= PH_MACK;
              end else begin
                txreg <= {txreg[DATA_W-2:0], 1'b1};
                cnt   <= cnt + 1'b1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_i;
            end else if (scl_fall) begin
              if (!nack_q) begin
                phase    <= PH_TX;
                cnt      <= CNT_W'(1);
                txreg    <= dc_q ? '1 : stat_data_i;
                stat_req <= ~dc_q;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = (phase == PH_ACK) | ((phase == PH_TX) & ~txreg[DATA_W-1]);
  assign byte_val = shreg;
endmodule

// File: rtl/dc_byte_router.sv
module dc_byte_router #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              dc,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              ram_valid,
  output logic [DATA_W-1:0] ram_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      ram_valid <= 1'b0;
      cmd_data  <= '0;
      ram_data  <= '0;
    end else begin
      cmd_valid <= byte_done & ~dc;
      ram_valid <= byte_done & dc;
      if (byte_done && !dc) cmd_data <= byte_val;
      if (byte_done && dc)  ram_data <= byte_val;
    end
  end
endmodule

// File: rtl/i2c_dispctl_slave.sv
module i2c_dispctl_slave #(
  parameter int ADDR_W = 7,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-SEL_W-1:0] ADDR_HI = 5'b01111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  addr_sel,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              ram_valid_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              stat_req_o,
  input  logic [DATA_W-1:0] stat_data_i
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, dc_q;
  logic [DATA_W-1:0] byte_val;

  dc_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  dc_link_fsm #(
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W),
    .ADDR_HI (ADDR_HI)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_i       (sda_i),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .addr_sel    (addr_sel),
    .stat_data_i (stat_data_i),
    .sda_oe      (sda_oe_o),
    .byte_done   (byte_done),
    .byte_val    (byte_val),
    .dc_q        (dc_q),
    .stat_req    (stat_req_o)
  );

  dc_byte_router #(.DATA_W(DATA_W)) u_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .dc        (dc_q),
    .cmd_valid (cmd_valid_o),
    .cmd_data  (cmd_data_o),
    .ram_valid (ram_valid_o),
    .ram_data  (ram_data_o)
  );
endmodule

// File: rtl/dc_i2c_checker.sv
module dc_i2c_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic cmd_valid_o,
  input logic ram_valid_o,
  input logic stat_req_o
);
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, ram_valid_o, stat_req_o}));

  assert_cmd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  assert_ram_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid_o |=> !ram_valid_o);

  assert_data_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || ram_valid_o) |-> !scl_i);

  assert_stat_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req_o |-> (!scl_i && $fell(scl_i) == 1'b0));
endmodule

bind i2c_dispctl_slave dc_i2c_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .cmd_valid_o (cmd_valid_o),
  .ram_valid_o (ram_valid_o),
  .stat_req_o  (stat_req_o)
);

// File: tb/i2c_dispctl_slave_tb.sv
`timescale 1ns/1ps
module i2c_dispctl_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] straps = 2'd0;
  logic sda_oe, cmd_v, ram_v, stat_req;
  logic [7:0] cmd_d, ram_d, stat_d;
  logic sda_line;

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] cmd_log [0:63];
  logic [7:0] ram_log [0:63];
  int cmd_n = 0;
  int ram_n = 0;
  int stat_n = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] stat_val(int k);
    return 8'((k * 37 + 90) & 255);
  endfunction

  assign stat_d = stat_val(stat_n);

  i2c_dispctl_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .addr_sel    (straps),
    .sda_oe_o    (sda_oe),
    .cmd_valid_o (cmd_v),
    .cmd_data_o  (cmd_d),
    .ram_valid_o (ram_v),
    .ram_data_o  (ram_d),
    .stat_req_o  (stat_req),
    .stat_data_i (stat_d)
  );

  always @(negedge clk) begin
    if (cmd_v && cmd_n < 64) begin cmd_log[cmd_n] <= cmd_d; cmd_n <= cmd_n + 1; end
    if (ram_v && ram_n < 64) begin ram_log[ram_n] <= ram_d; ram_n <= ram_n + 1; end
    if (stat_req) stat_n <= stat_n + 1;
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(3);
    scl = 1'b1;   tick(4);
    sda_m = 1'b0; tick(4);
    scl = 1'b0;   tick(2);
  endtask

  task automatic i2c_stop();
    tick(2);
    sda_m = 1'b0; tick(3);
    scl = 1'b1;   tick(4);
    sda_m = 1'b1; tick(4);
  endtask

  task automatic write_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(2); sda_m = b[i]; tick(3);
      scl = 1'b1; tick(5);
      scl = 1'b0;
    end
  endtask

  task automatic write_byte(logic [7:0] b, output logic ack);
    write_bits(b, 8);
    tick(2); sda_m = 1'b1; tick(3);
    scl = 1'b1; tick(2);
    ack = (sda_line == 1'b0);
    tick(3);
    scl = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      tick(5); scl = 1'b1; tick(2);
      b[i] = sda_line;
      tick(3); scl = 1'b0;
    end
    tick(2); sda_m = give_ack ? 1'b0 : 1'b1; tick(3);
    scl = 1'b1; tick(5);
    scl = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack, all_ack;
    logic [7:0] rb;
    int c0, r0, s0;
    logic [7:0] wa;

    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R11 R12: reset state
    check("R11 reset oe", int'(sda_oe), 0);
    check("R12 reset strobes", int'({cmd_v, ram_v, stat_req}), 0);

    // R1: sweep every address under every strap setting
    for (int s = 0; s < 4; s++) begin
      straps = 2'(s);
      for (int a = 0; a < 128; a++) begin
        i2c_start();
        write_byte({7'(a), 1'b0}, ack);
        i2c_stop();
        check($sformatf("R1 addr %0h strap %0d", a, s), int'(ack),
              int'(a == (60 + s)));
      end
    end
    check("R1 no strobes after sweep", cmd_n + ram_n + stat_n, 0);

    straps = 2'd2;
    wa = {5'b01111, 2'd2, 1'b0};

    // R1: wrong address is ignored, including data bytes and reads
    i2c_start();
    write_byte(8'h7A, ack);
    write_byte(8'h40, ack);
    write_byte(8'h55, ack);
    i2c_stop();
    check("R1 ignored write strobes", cmd_n + ram_n, 0);
    i2c_start();
    write_byte(8'h7B, ack);
    read_byte(rb, 1'b0);
    i2c_stop();
    check("R1 ignored read data", int'(rb), 8'hFF);
    check("R1 ignored read no stat", stat_n, 0);

    // R7 R10: read right after reset uses D/C=0
    i2c_start();
    write_byte(wa | 8'h01, ack);
    check("R2 read addr ack", int'(ack), 1);
    read_byte(rb, 1'b1); check("R7 status byte 0", int'(rb), int'(stat_val(0)));
    read_byte(rb, 1'b1); check("R7 status byte 1", int'(rb), int'(stat_val(1)));
    read_byte(rb, 1'b0); check("R7 status byte 2", int'(rb), int'(stat_val(2)));
    check("R10 reset dc status count", stat_n, 3);
    read_byte(rb, 1'b0);
    check("R7 released after nack", int'(rb), 8'hFF);
    check("R7 no request after nack", stat_n, 3);
    i2c_stop();

    // R5 R6 R2: Co=0 D/C=1 stream
    r0 = ram_n; c0 = cmd_n; all_ack = 1'b1;
    i2c_start();
    write_byte(wa, ack); all_ack &= ack;
    write_byte(8'h40, ack); all_ack &= ack;
    write_byte(8'h11, ack); all_ack &= ack;
    write_byte(8'h22, ack); all_ack &= ack;
    write_byte(8'h33, ack); all_ack &= ack;
    write_byte(8'hEE, ack); all_ack &= ack;
    i2c_stop();
    check("R2 all bytes acked", int'(all_ack), 1);
    check("R5 stream ram count", ram_n - r0, 4);
    check("R6 stream no cmd", cmd_n - c0, 0);
    check("R6 ram byte 0", int'(ram_log[r0]), 8'h11);
    check("R6 ram byte 1", int'(ram_log[r0+1]), 8'h22);
    check("R6 ram byte 2", int'(ram_log[r0+2]), 8'h33);
    check("R5 ram byte 3", int'(ram_log[r0+3]), 8'hEE);

    // R4 R6: Co=1 interleaved pairs
    r0 = ram_n; c0 = cmd_n;
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h80, ack);
    write_byte(8'hA1, ack);
    write_byte(8'hC0, ack);
    write_byte(8'hB2, ack);
    write_byte(8'h80, ack);
    write_byte(8'hC3, ack);
    i2c_stop();
    check("R4 pair cmd count", cmd_n - c0, 2);
    check("R4 pair ram count", ram_n - r0, 1);
    check("R6 pair cmd 0", int'(cmd_log[c0]), 8'hA1);
    check("R6 pair ram 0", int'(ram_log[r0]), 8'hB2);
    check("R4 pair cmd 1", int'(cmd_log[c0+1]), 8'hC3);

    // R3: reserved bits ignored
    r0 = ram_n; c0 = cmd_n;
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h7F, ack);
    write_byte(8'h5D, ack);
    write_byte(8'h6C, ack);
    i2c_stop();
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h3F, ack);
    write_byte(8'h6E, ack);
    i2c_stop();
    check("R3 reserved set ram count", ram_n - r0, 2);
    check("R3 reserved ram byte", int'(ram_log[r0+1]), 8'h6C);
    check("R3 reserved set cmd count", cmd_n - c0, 1);
    check("R3 reserved cmd byte", int'(cmd_log[c0]), 8'h6E);

    // R10 R9: Co mode ends at STOP, first byte is control
    r0 = ram_n; c0 = cmd_n;
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h00, ack);
    write_byte(8'h01, ack);
    i2c_stop();
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'hC0, ack);
    write_byte(8'h77, ack);
    write_byte(8'h80, ack);
    write_byte(8'h99, ack);
    i2c_stop();
    check("R10 ram after stop", ram_n - r0, 1);
    check("R10 ram byte", int'(ram_log[r0]), 8'h77);
    check("R9 cmd count", cmd_n - c0, 2);
    check("R9 cmd byte", int'(cmd_log[c0+1]), 8'h99);

    // R9: repeated START mid-byte during a stream
    r0 = ram_n; c0 = cmd_n;
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h40, ack);
    write_byte(8'h10, ack);
    write_bits(8'hFF, 3);
    i2c_start();
    write_byte(wa, ack);
    check("R9 addr ack after restart", int'(ack), 1);
    write_byte(8'h00, ack);
    write_byte(8'h12, ack);
    i2c_stop();
    check("R9 ram before restart", ram_n - r0, 1);
    check("R9 cmd after restart", cmd_n - c0, 1);
    check("R9 cmd byte after restart", int'(cmd_log[c0]), 8'h12);

    // R8 R10: D/C=1 persists across STOP, read releases SDA
    s0 = stat_n;
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h40, ack);
    i2c_stop();
    i2c_start();
    write_byte(wa | 8'h01, ack);
    read_byte(rb, 1'b1); check("R8 dc1 read byte 0", int'(rb), 8'hFF);
    read_byte(rb, 1'b0); check("R8 dc1 read byte 1", int'(rb), 8'hFF);
    i2c_stop();
    check("R8 no status request", stat_n - s0, 0);

    // R10: D/C=0 persists across repeated START into a read
    i2c_start();
    write_byte(wa, ack);
    write_byte(8'h00, ack);
    i2c_start();
    write_byte(wa | 8'h01, ack);
    read_byte(rb, 1'b0);
    i2c_stop();
    check("R10 status after restart", int'(rb), int'(stat_val(s0)));
    check("R10 status count after restart", stat_n - s0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule